// File: doc/BRIEF.md
# Base Address Region Decoder

This block turns the raw contents of a device's base address registers into the set of address windows that are actually live on the bus. It has six general regions plus one expansion ROM region. For each region it takes the raw register value, a size and a space type (I/O or memory). It uses these together with the two space enables of the command register to decide whether the region is mapped, and if so at which aligned base. A region that fails any check is parked at the all-ones marker and reported as unmapped.

The decoded bases are held in registers. Whenever the effective base of any region moves, including into or out of the unmapped state, the block raises a per-region flag and a summary pulse for one cycle. Mapping logic downstream can then rebuild its windows only when needed. The block also gives each region's write mask and its configuration-space offset. An address comparator reports which live regions claim an incoming address in a given space.

Top module: `bar_map_decoder`

## Requirements
- R1: A region size is valid only when it is a nonzero power of two. A region with an invalid size is never mapped and its write mask is zero. A valid region's write mask is ~(size-1), and the ROM region's mask also has bit 0 set.
- R2: The effective base is the raw value ANDed with ~(size-1). Changing raw bits below the size boundary does not change the base and raises no change pulse.
- R3: An I/O region (regionIsIo=1, not the ROM) is mapped only while cmdIoEn is 1. It is unmapped when its base is zero, when base+size-1 is not above the base, or when base+size-1 is 0x10000 or higher.
- R4: A memory region is mapped only while cmdMemEn is 1. It is unmapped when its base is zero, when the range wraps, or when base+size-1 equals all ones.
- R5: The ROM region (index NUM_BARS) is always memory space whatever its regionIsIo bit. It also needs bit 0 of its raw value set to be mapped.
- R6: regionBase and regionMapped show the decode of the inputs sampled at the previous rising clock edge. An unmapped region shows a base of all ones. regionMoved[i] and mapChanged are high for exactly one cycle after an edge at which region i's (or any region's) effective base changed, and low otherwise.
- R7: regionCfgOffset gives 0x10+4*n for general region n. For the ROM it gives 0x30, or 0x38 when headerType[6:0] equals 0x01; bit 7 of headerType is ignored.
- R8: hitVec[i] is 1 when region i is mapped, (hitAddr AND ~(size_i-1)) equals its registered base, and hitIsIo matches the region's space.
- R9: While rstN is low, every base is all ones, no region is mapped, and regionMoved and mapChanged are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdIoEn | input | 1 | Command register I/O space enable |
| cmdMemEn | input | 1 | Command register memory space enable |
| headerType | input | 8 | Header type byte (bit 7 is the multifunction flag) |
| regionRaw | input | (NUM_BARS+1)*ADDR_W | Raw register value per region, ROM last |
| regionSize | input | (NUM_BARS+1)*ADDR_W | Region size per region |
| regionIsIo | input | NUM_BARS+1 | 1 = I/O space region (ignored for the ROM) |
| hitAddr | input | ADDR_W | Address to compare against the live regions |
| hitIsIo | input | 1 | Space of hitAddr, 1 = I/O |
| regionMapped | output | NUM_BARS+1 | Region currently mapped |
| regionBase | output | (NUM_BARS+1)*ADDR_W | Registered effective base, all ones when unmapped |
| regionWrMask | output | (NUM_BARS+1)*ADDR_W | Writable bits of each region register |
| regionCfgOffset | output | (NUM_BARS+1)*8 | Configuration-space offset of each region register |
| regionMoved | output | NUM_BARS+1 | One-cycle flag: this region's base moved |
| mapChanged | output | 1 | One-cycle pulse: some region's base moved |
| hitVec | output | NUM_BARS+1 | Regions claiming hitAddr |

## Verification
The assertions assume that the inputs settle between clock edges, so that the previous-cycle enables, space types and ROM enable bit explain every mapped region. The comparator assumes that region sizes do not change while the registered base from the old size is still shown. The stimulus changes inputs only one nanosecond after a rising edge. It holds each region's size steady for at least two edges after a change, and in the randomized phase it varies only raw values and enables, never sizes. The reference model recomputes each region's target base from the requirements on every edge and compares it with every output.

// File: rtl/bar_map_pkg.sv
package bar_map_pkg;

  // Bit of the ROM register that enables decoding
  localparam int ROM_EN_BIT = 0;

  // Header kind code meaning a bridge, compared with bit 7 masked off
  localparam logic [7:0] HDR_KIND_MASK  = 8'h7F;
  localparam logic [7:0] HDR_KIND_BRIDGE = 8'h01;

  // Configuration-space placement of the region registers
  localparam int         BAR_OFS_BASE   = 'h10;
  localparam int         BAR_OFS_STRIDE = 4;
  localparam logic [7:0] ROM_OFS_NORMAL = 8'h30;
  localparam logic [7:0] ROM_OFS_BRIDGE = 8'h38;

  // Strobes from control to datapath, one per region
  typedef struct packed {
    logic load;      // region register takes a new value this edge
    logic unmapSel;  // new value is the unmapped marker, not the aligned base
  } regionStrobe_t;

  function automatic logic isPow2(input logic [63:0] v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/bar_map_datapath.sv
module bar_map_datapath
  import bar_map_pkg::*;
#(
  parameter int          NUM_BARS = 6,
  parameter int          ADDR_W   = 32,
  parameter longint unsigned IO_LIMIT = 64'h10000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cmdIoEn,
  input  logic                              cmdMemEn,
  input  logic [7:0]                        headerType,
  input  logic [NUM_BARS:0][ADDR_W-1:0]     regionRaw,
  input  logic [NUM_BARS:0][ADDR_W-1:0]     regionSize,
  input  logic [NUM_BARS:0]                 regionIsIo,
  input  logic [ADDR_W-1:0]                 hitAddr,
  input  logic                              hitIsIo,
  input  regionStrobe_t [NUM_BARS:0]        strobe,
  output logic [NUM_BARS:0][ADDR_W-1:0]     alignedBase,
  output logic [NUM_BARS:0]                 regionOk,
  output logic [NUM_BARS:0][ADDR_W-1:0]     baseQ,
  output logic [NUM_BARS:0]                 regionMapped,
  output logic [NUM_BARS:0][ADDR_W-1:0]     regionWrMask,
  output logic [NUM_BARS:0][7:0]            regionCfgOffset,
  output logic [NUM_BARS:0]                 hitVec
);

  localparam int NREG    = NUM_BARS + 1;
  localparam int ROM_IDX = NUM_BARS;
  localparam logic [ADDR_W-1:0] UNMAPPED = '1;

  logic isBridge;
  assign isBridge = ((headerType & HDR_KIND_MASK) == HDR_KIND_BRIDGE);

  for (genvar g = 0; g < NREG; g++) begin : gRegion
    logic              isIo;
    logic              sizeOk;
    logic              enableOk;
    logic              romEnOk;
    logic              rangeOk;
    logic [ADDR_W-1:0] sizeMask;
    logic [ADDR_W-1:0] lastAddr;
    logic [ADDR_W-1:0] maskExtra;

    always_comb begin
      isIo      = (g == ROM_IDX) ? 1'b0 : regionIsIo[g];
      sizeOk    = isPow2(64'(regionSize[g]));
      sizeMask  = ~(regionSize[g] - {{(ADDR_W-1){1'b0}}, 1'b1});
      maskExtra = (g == ROM_IDX) ? {{(ADDR_W-1){1'b0}}, 1'b1} : '0;
      alignedBase[g] = regionRaw[g] & sizeMask;
      lastAddr  = alignedBase[g] + regionSize[g] - {{(ADDR_W-1){1'b0}}, 1'b1};
      enableOk  = isIo ? cmdIoEn : cmdMemEn;
      romEnOk   = (g != ROM_IDX) || regionRaw[g][ROM_EN_BIT];
      rangeOk   = (alignedBase[g] != '0) && (lastAddr > alignedBase[g]);
      if (isIo) begin
        rangeOk = rangeOk && (64'(lastAddr) < IO_LIMIT);
      end else begin
        rangeOk = rangeOk && (lastAddr != UNMAPPED);
      end
      regionOk[g]     = sizeOk && enableOk && romEnOk && rangeOk;
      regionWrMask[g] = sizeOk ? (sizeMask | maskExtra) : '0;
    end

    if (g == ROM_IDX) begin : gRomOfs
      assign regionCfgOffset[g] = isBridge ? ROM_OFS_BRIDGE : ROM_OFS_NORMAL;
    end else begin : gBarOfs
      assign regionCfgOffset[g] = 8'(BAR_OFS_BASE + BAR_OFS_STRIDE * g);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[g] <= UNMAPPED;
      end else if (strobe[g].load) begin
        baseQ[g] <= strobe[g].unmapSel ? UNMAPPED : alignedBase[g];
      end
    end

    assign regionMapped[g] = (baseQ[g] != UNMAPPED);
    assign hitVec[g] = regionMapped[g] && ((hitAddr & sizeMask) == baseQ[g])
                       && (hitIsIo == isIo);

    // R6
    load_moves_base_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].load |=> (baseQ[g] != $past(baseQ[g])));

    if (g == ROM_IDX) begin : gRomChk
      // R5
      rom_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
        regionMapped[g] |-> ($past(regionRaw[g][ROM_EN_BIT]) && $past(cmdMemEn)));
    end else begin : gBarChk
      // R3
      io_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regionMapped[g] && $past(regionIsIo[g])) |-> $past(cmdIoEn));
      // R4
      mem_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regionMapped[g] && !$past(regionIsIo[g])) |-> $past(cmdMemEn));
    end
  end

endmodule

// File: rtl/bar_map_control.sv
module bar_map_control
  import bar_map_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int ADDR_W   = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BARS:0][ADDR_W-1:0] alignedBase,
  input  logic [NUM_BARS:0]             regionOk,
  input  logic [NUM_BARS:0][ADDR_W-1:0] baseQ,
  output regionStrobe_t [NUM_BARS:0]    strobe,
  output logic [NUM_BARS:0]             regionMoved,
  output logic                          mapChanged
);

  localparam int NREG = NUM_BARS + 1;
  localparam logic [ADDR_W-1:0] UNMAPPED = '1;

  logic [NREG-1:0]             loadVec;
  logic [NREG-1:0][ADDR_W-1:0] target;

  for (genvar g = 0; g < NREG; g++) begin : gCmp
    always_comb begin
      target[g]          = regionOk[g] ? alignedBase[g] : UNMAPPED;
      loadVec[g]         = (target[g] != baseQ[g]);
      strobe[g].load     = loadVec[g];
      strobe[g].unmapSel = !regionOk[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionMoved <= '0;
      mapChanged  <= 1'b0;
    end else begin
      regionMoved <= loadVec;
      mapChanged  <= |loadVec;
    end
  end

  // R6
  pulse_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|loadVec) |=> mapChanged);

  // R6
  pulse_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapChanged |-> $past(|loadVec));

  // R6
  moved_within_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regionMoved != '0) |-> mapChanged);

endmodule

// File: rtl/bar_map_decoder.sv
module bar_map_decoder
  import bar_map_pkg::*;
#(
  parameter int              NUM_BARS = 6,
  parameter int              ADDR_W   = 32,
  parameter longint unsigned IO_LIMIT = 64'h10000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdIoEn,
  input  logic                          cmdMemEn,
  input  logic [7:0]                    headerType,
  input  logic [NUM_BARS:0][ADDR_W-1:0] regionRaw,
  input  logic [NUM_BARS:0][ADDR_W-1:0] regionSize,
  input  logic [NUM_BARS:0]             regionIsIo,
  input  logic [ADDR_W-1:0]             hitAddr,
  input  logic                          hitIsIo,
  output logic [NUM_BARS:0]             regionMapped,
  output logic [NUM_BARS:0][ADDR_W-1:0] regionBase,
  output logic [NUM_BARS:0][ADDR_W-1:0] regionWrMask,
  output logic [NUM_BARS:0][7:0]        regionCfgOffset,
  output logic [NUM_BARS:0]             regionMoved,
  output logic                          mapChanged,
  output logic [NUM_BARS:0]             hitVec
);

  regionStrobe_t [NUM_BARS:0]        strobe;
  logic [NUM_BARS:0][ADDR_W-1:0]     alignedBase;
  logic [NUM_BARS:0]                 regionOk;
  logic [NUM_BARS:0][ADDR_W-1:0]     baseQ;

  bar_map_datapath #(
    .NUM_BARS (NUM_BARS),
    .ADDR_W   (ADDR_W),
    .IO_LIMIT (IO_LIMIT)
  ) u_path (
    .clk             (clk),
    .rstN            (rstN),
    .cmdIoEn         (cmdIoEn),
    .cmdMemEn        (cmdMemEn),
    .headerType      (headerType),
    .regionRaw       (regionRaw),
    .regionSize      (regionSize),
    .regionIsIo      (regionIsIo),
    .hitAddr         (hitAddr),
    .hitIsIo         (hitIsIo),
    .strobe          (strobe),
    .alignedBase     (alignedBase),
    .regionOk        (regionOk),
    .baseQ           (baseQ),
    .regionMapped    (regionMapped),
    .regionWrMask    (regionWrMask),
    .regionCfgOffset (regionCfgOffset),
    .hitVec          (hitVec)
  );

  bar_map_control #(
    .NUM_BARS (NUM_BARS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .alignedBase (alignedBase),
    .regionOk    (regionOk),
    .baseQ       (baseQ),
    .strobe      (strobe),
    .regionMoved (regionMoved),
    .mapChanged  (mapChanged)
  );

  assign regionBase = baseQ;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!rstN -> (regionMapped == '0 && !mapChanged)));

endmodule

// File: tb/bar_map_decoder_tb.sv
module bar_map_decoder_tb;

  localparam int NB = 6;
  localparam int NR = NB + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdIo = 1'b0, cmdMem = 1'b0;
  logic [7:0] hdr = 8'h00;
  logic [NB:0][31:0] rawV = '0;
  logic [NB:0][31:0] sizeV = '0;
  logic [NB:0] isIoV = '0;
  logic [31:0] hAddr = '0;
  logic hIo = 1'b0;

  logic [NB:0] mappedO, movedO, hitO;
  logic [NB:0][31:0] baseO, maskO;
  logic [NB:0][7:0] ofsO;
  logic changedO;

  int nChecks = 0;
  int nFail = 0;

  logic [31:0] expBase [NR];
  logic        expMoved [NR];

  always #2 clk = ~clk;

  bar_map_decoder u_dut (
    .clk(clk), .rstN(rstN), .cmdIoEn(cmdIo), .cmdMemEn(cmdMem),
    .headerType(hdr), .regionRaw(rawV), .regionSize(sizeV), .regionIsIo(isIoV),
    .hitAddr(hAddr), .hitIsIo(hIo), .regionMapped(mappedO), .regionBase(baseO),
    .regionWrMask(maskO), .regionCfgOffset(ofsO), .regionMoved(movedO),
    .mapChanged(changedO), .hitVec(hitO)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int idx, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s[%0d] actual=%h expected=%h", tag, what, idx, act, exp);
    end
  endtask

  function automatic bit sizeGood(input logic [31:0] s);
    return (s != 0) && ((s & (s - 32'd1)) == 0);
  endfunction

  function automatic bit spaceIo(input int i);
    return (i == NB) ? 1'b0 : isIoV[i];
  endfunction

  // Target base from the requirements: all ones means unmapped
  function automatic logic [31:0] expTarget(input int i);
    logic [31:0] sz, b, l;
    bit io;
    sz = sizeV[i];
    if (!sizeGood(sz)) return '1;                  // R1
    io = spaceIo(i);
    if (io ? !cmdIo : !cmdMem) return '1;          // R3 / R4
    if (i == NB && !rawV[i][0]) return '1;         // R5
    b = rawV[i] & ~(sz - 32'd1);                   // R2
    l = b + sz - 32'd1;
    if (b == 0 || l <= b) return '1;
    if (io && l >= 32'h10000) return '1;           // R3
    if (!io && l == 32'hFFFF_FFFF) return '1;      // R4
    return b;
  endfunction

  task automatic compareAll();
    bit anyMoved;
    anyMoved = 1'b0;
    for (int i = 0; i < NR; i++) begin
      string kind;
      logic [31:0] expMask, expOfs;
      bit expMap, expHit;
      kind = (i == NB) ? "R5" : (isIoV[i] ? "R3" : "R4");
      expMap = (expBase[i] != 32'hFFFF_FFFF);
      chk(mappedO[i] == expMap, kind, "mapped", i, 32'(mappedO[i]), 32'(expMap));
      chk(baseO[i] == expBase[i], "R2", "base", i, baseO[i], expBase[i]);
      expMask = sizeGood(sizeV[i]) ? (~(sizeV[i] - 32'd1) | ((i == NB) ? 32'd1 : 32'd0)) : 32'd0;
      chk(maskO[i] == expMask, "R1", "wrMask", i, maskO[i], expMask);
      if (i == NB) expOfs = (hdr[6:0] == 7'h01) ? 32'h38 : 32'h30;
      else expOfs = 32'h10 + 32'(4 * i);
      chk(32'(ofsO[i]) == expOfs, "R7", "cfgOffset", i, 32'(ofsO[i]), expOfs);
      expHit = expMap && ((hAddr & ~(sizeV[i] - 32'd1)) == expBase[i]) && (hIo == spaceIo(i));
      chk(hitO[i] == expHit, "R8", "hit", i, 32'(hitO[i]), 32'(expHit));
      chk(movedO[i] == expMoved[i], "R6", "moved", i, 32'(movedO[i]), 32'(expMoved[i]));
      anyMoved = anyMoved | expMoved[i];
    end
    chk(changedO == anyMoved, "R6", "mapChanged", 0, 32'(changedO), 32'(anyMoved));
  endtask

  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      if (!rstN) begin
        expBase[i] = '1;
        expMoved[i] = 1'b0;
      end else begin
        logic [31:0] t;
        t = expTarget(i);
        expMoved[i] = (t != expBase[i]);
        expBase[i] = t;
      end
    end
    #1;
    compareAll();
  endtask

  task automatic settle();
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      expBase[i] = '1;
      expMoved[i] = 1'b0;
    end
    // R9: reset state with enables and valid-looking regions present
    cmdIo = 1'b1; cmdMem = 1'b1;
    sizeV[0] = 32'h1000; rawV[0] = 32'h4000_0000;
    repeat (3) tick();
    chk(mappedO == '0, "R9", "mappedInReset", 0, 32'(mappedO), 32'h0);
    chk(!changedO, "R9", "changedInReset", 0, 32'(changedO), 32'h0);
    chk(baseO[0] == 32'hFFFF_FFFF, "R9", "baseInReset", 0, baseO[0], 32'hFFFF_FFFF);
    cmdIo = 1'b0; cmdMem = 1'b0; sizeV[0] = '0; rawV[0] = '0;
    @(negedge clk); rstN = 1'b1;
    settle();

    // R4 / R6: memory region appears with the memory enable
    sizeV[0] = 32'h1000; rawV[0] = 32'h8000_0000; cmdMem = 1'b1;
    settle();
    // R2: bits below the size boundary do not move the base
    rawV[0] = 32'h8000_0ABC;
    settle();
    // R3: I/O region with type bit in the raw value
    sizeV[1] = 32'h100; isIoV[1] = 1'b1; rawV[1] = 32'h0000_C001; cmdIo = 1'b1;
    settle();
    // R8: hits in both spaces
    hAddr = 32'h8000_0123; hIo = 1'b0; tick();
    hIo = 1'b1; tick();
    hAddr = 32'h0000_C0FF; tick();
    hAddr = 32'h0000_C100; tick();
    // R3: last address exactly 0xFFFF stays mapped; 0x10000 and above does not
    rawV[1] = 32'h0000_FF00; settle();
    rawV[1] = 32'h0001_0000; settle();
    // R3: zero base
    sizeV[2] = 32'h100; isIoV[2] = 1'b1; rawV[2] = 32'h0000_0001; settle();
    // R1: non power-of-two size
    sizeV[3] = 32'h3000; rawV[3] = 32'h9000_0000; settle();
    // R4: last address reaching all ones, then a window just below it
    sizeV[4] = 32'h1000; rawV[4] = 32'hFFFF_F000; settle();
    sizeV[4] = 32'h2000; rawV[4] = 32'hFFFF_C000; settle();
    // R5: ROM needs its enable bit; its type bit is ignored
    sizeV[NB] = 32'h1_0000; isIoV[NB] = 1'b1; rawV[NB] = 32'hA000_0000; settle();
    rawV[NB] = 32'hA000_0001; settle();
    hAddr = 32'hA000_1234; hIo = 1'b0; tick();
    // R7: header kinds
    hdr = 8'h01; tick();
    hdr = 8'h81; tick();
    hdr = 8'h02; tick();
    // R6: dropping both enables unmaps everything in one step
    rawV[1] = 32'h0000_C000; settle();
    cmdIo = 1'b0; cmdMem = 1'b0; settle();
    cmdIo = 1'b1; cmdMem = 1'b1; settle();
    // Randomized raw values and enables with fixed sizes
    sizeV[5] = 32'h10; isIoV[5] = 1'b1;
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < NR; i++) begin
        case ($urandom_range(3))
          0: rawV[i] = $urandom;
          1: rawV[i] = $urandom & 32'h0001_FFFF;
          2: rawV[i] = rawV[i] | 32'h0000_0003;
          default: ;
        endcase
      end
      if ($urandom_range(7) == 0) cmdIo = ~cmdIo;
      if ($urandom_range(7) == 0) cmdMem = ~cmdMem;
      hIo = 1'($urandom_range(1));
      hAddr = rawV[$urandom_range(NB)];
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule